// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This core executes a program made of a single kind of instruction: a move that copies one word from a source port to a destination port. It has no opcode field. Arithmetic and logic happen as a side effect of data reaching the trigger port of a functional unit. An adder, a subtractor and a bitwise logic unit each hold a first operand and produce one result register. The result is read back by a later move. The outside world is reached through a communication unit whose input and output ports are move endpoints like any other.

Each 16-bit instruction word holds a source address in bits [15:8] and a destination address in bits [7:0]. Every address splits into a unit id in its upper nibble and a port id in its lower nibble. There is no pipeline. A plain move finishes in the cycle its word is presented on the instruction bus. A move whose source is the immediate endpoint takes one more cycle, because its value is the next instruction word. A new unit only claims an unused unit id. The word layout, the fetch logic and the bus stay unchanged.

Top module: `move_core`

## Requirements
- R1: An instruction word carries the source unit in [15:12], the source port in [11:8], the destination unit in [7:4] and the destination port in [3:0]. A move that neither stalls nor jumps advances `imem_addr` by one per clock.
- R2: The adder is unit 1. A write to 0x10 stores the first operand. A write to 0x11 triggers the unit. From the next instruction on, source 0x18 returns the sum of the first operand and the triggering value, modulo 2^DATA_W.
- R3: A write to a first-operand port (0x10, 0x20 or 0x30) leaves that unit's result unchanged until its trigger port is written.
- R4: The subtractor is unit 2. Port 0x20 stores the first operand. Port 0x21 triggers first operand minus triggering value, modulo 2^DATA_W. Port 0x28 is the result.
- R5: The logic unit is unit 3. Port 0x30 stores the first operand. The trigger port selects the operation: 0x31 gives AND, 0x32 gives OR and 0x33 gives XOR. Port 0x38 is the result.
- R6: Source address 0x00 is the immediate endpoint. The moved value is the instruction word that follows, and `imem_addr` advances by two over the two cycles of that move.
- R7: Destination address 0x01 is the program counter. Moving a value there makes the next fetch come from the low PC_W bits of that value.
- R8: Source address 0x40 reads `in_data`. While such a move waits, `in_ready` is high and `imem_addr` holds. The word is taken on the clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for every other instruction.
- R9: Destination address 0x41 drives the moved value onto `out_data`, and `out_valid` goes high for the cycle after that move.
- R10: A move that names an unmapped source or destination sets a sticky `error` flag and makes the core halt. After that, `halted` stays high, `imem_addr` no longer changes and no further output is produced.
- R11: After reset, `imem_addr` is 0, `error`, `halted`, `out_valid` and `in_ready` are low, and all unit results read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_addr | output | PC_W | Address of the instruction word being executed |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, combinational read |
| in_data | input | DATA_W | Word offered by the outside world |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Core is executing a read of the input endpoint |
| out_data | output | DATA_W | Last word moved to the output endpoint |
| out_valid | output | 1 | `out_data` was written by the previous move |
| error | output | 1 | Sticky: an unmapped address was used |
| halted | output | 1 | Core has stopped executing |

## Verification
The assertions check five properties on every cycle. The error flag never clears. A halted core keeps its program counter. A stalled input read holds the program counter. A first-operand write leaves a unit's result alone. Every output move shows up on the following cycle with the moved value. Only the bench's programs can show that sums, differences and the three logic operations come out right, including wraparound. They also show that the immediate word and jump targets steer the fetch sequence, that data flows through the input handshake across arbitrary waits, and that unmapped addresses stop output for good.

// File: rtl/move_pkg.sv
package move_pkg;

    localparam int INSTR_W  = 16;
    localparam int ADDR_W   = 8;
    localparam int N_FU     = 3;
    localparam int FU_IDX_W = 2;

    localparam int FU_ADD   = 0;
    localparam int FU_SUB   = 1;
    localparam int FU_LOGIC = 2;

    localparam logic [3:0] UNIT_CTRL = 4'h0;
    localparam logic [3:0] FU_BASE   = 4'h1;
    localparam logic [3:0] UNIT_COMM = 4'h4;

    localparam logic [3:0] PORT_IMM  = 4'h0;
    localparam logic [3:0] PORT_PC   = 4'h1;
    localparam logic [3:0] PORT_CIN  = 4'h0;
    localparam logic [3:0] PORT_COUT = 4'h1;
    localparam logic [3:0] PORT_OP1  = 4'h0;
    localparam logic [3:0] PORT_RES  = 4'h8;

    typedef enum logic [1:0] {SRC_NONE, SRC_IMM, SRC_RES, SRC_IN} src_kind_e;
    typedef enum logic [2:0] {DST_NONE, DST_PC, DST_OP1, DST_TRIG, DST_OUT} dst_kind_e;
    typedef enum logic [1:0] {ST_RUN, ST_IMM, ST_HALT} core_state_e;

    function automatic int trig_ports(int kind);
        return (kind == FU_LOGIC) ? 3 : 1;
    endfunction

endpackage

// File: rtl/move_decode.sv
module move_decode
    import move_pkg::*;
(
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    output src_kind_e           src_kind,
    output logic [FU_IDX_W-1:0] src_fu,
    output dst_kind_e           dst_kind,
    output logic [FU_IDX_W-1:0] dst_fu,
    output logic [1:0]          trig_op
);

    logic [3:0] s_unit, s_port, d_unit, d_port;

    always_comb begin
        s_unit   = src_addr[7:4];
        s_port   = src_addr[3:0];
        d_unit   = dst_addr[7:4];
        d_port   = dst_addr[3:0];
        src_kind = SRC_NONE;
        src_fu   = '0;
        dst_kind = DST_NONE;
        dst_fu   = '0;
        trig_op  = '0;

        if (s_unit == UNIT_CTRL && s_port == PORT_IMM) begin
            src_kind = SRC_IMM;
        end else if (s_unit == UNIT_COMM && s_port == PORT_CIN) begin
            src_kind = SRC_IN;
        end
        for (int g = 0; g < N_FU; g++) begin
            if (s_unit == FU_BASE + 4'(g) && s_port == PORT_RES) begin
                src_kind = SRC_RES;
                src_fu   = FU_IDX_W'(g);
            end
        end

        if (d_unit == UNIT_CTRL && d_port == PORT_PC) begin
            dst_kind = DST_PC;
        end else if (d_unit == UNIT_COMM && d_port == PORT_COUT) begin
            dst_kind = DST_OUT;
        end
        for (int g = 0; g < N_FU; g++) begin
            if (d_unit == FU_BASE + 4'(g)) begin
                if (d_port == PORT_OP1) begin
                    dst_kind = DST_OP1;
                    dst_fu   = FU_IDX_W'(g);
                end else if (d_port <= 4'(trig_ports(g))) begin
                    dst_kind = DST_TRIG;
                    dst_fu   = FU_IDX_W'(g);
                    trig_op  = 2'(d_port - 4'd1);
                end
            end
        end
    end

endmodule

// File: rtl/move_arith_fu.sv
module move_arith_fu #(
    parameter int DATA_W   = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op1_we,
    input  logic              trig_we,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] res;
    } arith_regs_t;

    arith_regs_t r_d, r_q;
    logic [DATA_W-1:0] calc;

    generate
        if (SUBTRACT) begin : g_sub
            assign calc = r_q.op1 - bus_data;
        end else begin : g_add
            assign calc = r_q.op1 + bus_data;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (op1_we)  r_d.op1 = bus_data;
        if (trig_we) r_d.res = calc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result = r_q.res;

    // R3: latching the first operand alone leaves the result untouched
    p_op1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_we && !trig_we) |=> $stable(result));

endmodule

// File: rtl/move_logic_fu.sv
module move_logic_fu #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op1_we,
    input  logic              trig_we,
    input  logic [1:0]        trig_op,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] res;
    } logic_regs_t;

    logic_regs_t r_d, r_q;
    logic [DATA_W-1:0] calc;

    always_comb begin
        case (trig_op)
            2'd0:    calc = r_q.op1 & bus_data;
            2'd1:    calc = r_q.op1 | bus_data;
            default: calc = r_q.op1 ^ bus_data;
        endcase
        r_d = r_q;
        if (op1_we)  r_d.op1 = bus_data;
        if (trig_we) r_d.res = calc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result = r_q.res;

    // R3: latching the first operand alone leaves the result untouched
    p_op1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_we && !trig_we) |=> $stable(result));

endmodule

// File: rtl/move_comm.sv
module move_comm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } comm_regs_t;

    comm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = wr_en;
        if (wr_en) r_d.data = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready  = rd_req;
    assign rd_ok     = rd_req && in_valid;
    assign rd_data   = in_data;
    assign out_data  = r_q.data;
    assign out_valid = r_q.valid;

    // R9: every output move is visible on the next cycle with its value
    p_out_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (out_valid && out_data == $past(wr_data)));

endmodule

// File: rtl/move_core.sv
module move_core
    import move_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_valid,
    output logic               error,
    output logic               halted
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        core_state_e       st;
        logic              err;
        logic [ADDR_W-1:0] imm_dst;
    } core_regs_t;

    core_regs_t r_d, r_q;

    logic [ADDR_W-1:0]   dst_addr;
    src_kind_e           src_kind;
    dst_kind_e           dst_kind;
    logic [FU_IDX_W-1:0] src_fu, dst_fu;
    logic [1:0]          trig_op;
    logic                move_en, rd_req, rd_ok;
    logic [DATA_W-1:0]   bus_val, rd_data;
    logic [DATA_W-1:0]   fu_res [N_FU];
    logic [N_FU-1:0]     op1_we, trig_we;

    assign dst_addr = (r_q.st == ST_IMM) ? r_q.imm_dst : imem_rdata[7:0];

    move_decode u_dec (
        .src_addr (imem_rdata[15:8]),
        .dst_addr (dst_addr),
        .src_kind (src_kind),
        .src_fu   (src_fu),
        .dst_kind (dst_kind),
        .dst_fu   (dst_fu),
        .trig_op  (trig_op)
    );

    assign rd_req = (r_q.st == ST_RUN) && (src_kind == SRC_IN) && (dst_kind != DST_NONE);

    always_comb begin
        r_d     = r_q;
        move_en = 1'b0;
        bus_val = '0;
        case (r_q.st)
            ST_RUN: begin
                if (src_kind == SRC_NONE || dst_kind == DST_NONE) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_HALT;
                end else if (src_kind == SRC_IMM) begin
                    r_d.imm_dst = imem_rdata[7:0];
                    r_d.pc      = r_q.pc + 1'b1;
                    r_d.st      = ST_IMM;
                end else if (src_kind == SRC_RES) begin
                    move_en = 1'b1;
                    bus_val = fu_res[src_fu];
                end else if (rd_ok) begin
                    move_en = 1'b1;
                    bus_val = rd_data;
                end
            end
            ST_IMM: begin
                move_en = 1'b1;
                bus_val = DATA_W'(imem_rdata);
                r_d.st  = ST_RUN;
            end
            default: ;
        endcase
        if (move_en) begin
            r_d.pc = (dst_kind == DST_PC) ? PC_W'(bus_val) : r_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pc: '0, st: ST_RUN, err: 1'b0, imm_dst: '0};
        else        r_q <= r_d;
    end

    generate
        for (genvar g = 0; g < N_FU; g++) begin : g_fu
            assign op1_we[g]  = move_en && dst_kind == DST_OP1  && dst_fu == FU_IDX_W'(g);
            assign trig_we[g] = move_en && dst_kind == DST_TRIG && dst_fu == FU_IDX_W'(g);
            if (g == FU_LOGIC) begin : g_logic
                move_logic_fu #(.DATA_W(DATA_W)) u_fu (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .op1_we   (op1_we[g]),
                    .trig_we  (trig_we[g]),
                    .trig_op  (trig_op),
                    .bus_data (bus_val),
                    .result   (fu_res[g])
                );
            end else begin : g_arith
                move_arith_fu #(.DATA_W(DATA_W), .SUBTRACT(g == FU_SUB)) u_fu (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .op1_we   (op1_we[g]),
                    .trig_we  (trig_we[g]),
                    .bus_data (bus_val),
                    .result   (fu_res[g])
                );
            end
        end
    endgenerate

    move_comm #(.DATA_W(DATA_W)) u_comm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .rd_ok     (rd_ok),
        .rd_data   (rd_data),
        .wr_en     (move_en && dst_kind == DST_OUT),
        .wr_data   (bus_val),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    assign imem_addr = r_q.pc;
    assign error     = r_q.err;
    assign halted    = (r_q.st == ST_HALT);

    // R10: the error flag never clears once set
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R10: a halted core stays halted with a frozen fetch address
    p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    // R8: an input read with no valid data holds the fetch address
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(imem_addr));

endmodule

// File: tb/tb_move_core.sv
module tb_move_core;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW = 16;
    localparam int  PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] imem_addr;
    logic [15:0]   imem_rdata;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready, out_valid, error, halted;
    logic [DW-1:0] out_data;

    logic [15:0]   prog [256];
    int            ptr;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic [DW-1:0] in_q  [$];
    int            n_vec = 0;
    int            n_bad = 0;
    int            cyc = 0;
    logic          fire = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = prog[imem_addr];

    move_core #(.DATA_W(DW), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .error(error), .halted(halted)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every output pulse
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9/R10 unexpected output", int'(out_data), 0);
            end else begin
                check(out_data == exp_q[0], tag_q[0], int'(out_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // Input feeder: offer queued words, drop one after each handshake edge
    always @(negedge clk) begin
        if (!rst_n) begin
            fire     = 1'b0;
            in_valid = 1'b0;
        end else begin
            if (fire) void'(in_q.pop_front());
            in_valid = (in_q.size() > 0);
            in_data  = (in_q.size() > 0) ? in_q[0] : '0;
            fire     = in_valid && in_ready;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [15:0] w);
        prog[ptr] = w;
        ptr++;
    endtask
    task automatic mv(input logic [7:0] s, input logic [7:0] d);
        put({s, d});
    endtask
    task automatic imm(input logic [15:0] v, input logic [7:0] d);
        put({8'h00, d});
        put(v);
    endtask
    task automatic park();
        int here;
        here = ptr;
        put(16'h0001);
        put(16'(here));
    endtask
    task automatic expect_out(input logic [DW-1:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask
    task automatic new_prog();
        for (int i = 0; i < 256; i++) prog[i] = 16'h5555;
        ptr = 0;
        in_q.delete();
    endtask
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask
    task automatic drain(input int maxc);
        int n;
        n = 0;
        while (exp_q.size() > 0 && n < maxc) begin
            @(negedge clk);
            n++;
        end
        while (exp_q.size() > 0) begin
            check(1'b0, tag_q[0], 0, int'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        // ---- Program 1: units, immediates, reset state ----
        new_prog();
        mv(8'h18, 8'h41);              expect_out(16'h0000, "R11 reset result");
        imm(16'd5, 8'h10);
        imm(16'd7, 8'h11);
        mv(8'h18, 8'h41);              expect_out(16'd12, "R2 add");
        imm(16'd100, 8'h10);
        mv(8'h18, 8'h41);              expect_out(16'd12, "R3 op1 no effect");
        imm(16'd1, 8'h11);
        mv(8'h18, 8'h41);              expect_out(16'd101, "R2 add after op1");
        imm(16'hFFFF, 8'h10);
        imm(16'd2, 8'h11);
        mv(8'h18, 8'h41);              expect_out(16'd1, "R2 add wrap");
        imm(16'd3, 8'h20);
        imm(16'd10, 8'h21);
        mv(8'h28, 8'h41);              expect_out(16'hFFF9, "R4 sub wrap");
        imm(16'hF0F0, 8'h30);
        imm(16'h3C3C, 8'h31);
        mv(8'h38, 8'h41);              expect_out(16'h3030, "R5 and");
        imm(16'h3C3C, 8'h32);
        mv(8'h38, 8'h41);              expect_out(16'hFCFC, "R5 or");
        imm(16'h3C3C, 8'h33);
        mv(8'h38, 8'h41);              expect_out(16'hCCCC, "R5 xor");
        imm(16'h1234, 8'h20);
        mv(8'h28, 8'h41);              expect_out(16'hFFF9, "R3 sub op1 no effect");
        park();
        do_reset();
        check(imem_addr == 0, "R11 pc", int'(imem_addr), 0);
        check(!error && !halted, "R11 flags", int'({error, halted}), 0);
        check(!out_valid && out_data == 0, "R11 output", int'(out_data), 0);
        check(!in_ready, "R8 ready low", int'(in_ready), 0);
        @(negedge clk);
        check(imem_addr == 1, "R1 plain move +1", int'(imem_addr), 1);
        @(negedge clk);
        @(negedge clk);
        check(imem_addr == 3, "R6 immediate +2", int'(imem_addr), 3);
        drain(400);

        // ---- Program 2: jump ----
        new_prog();
        imm(16'd4, 8'h01);
        imm(16'hDEAD, 8'h41);
        imm(16'h0077, 8'h41);          expect_out(16'h0077, "R7 jump target");
        park();
        do_reset();
        @(negedge clk);
        @(negedge clk);
        check(imem_addr == 4, "R7 pc loaded", int'(imem_addr), 4);
        drain(100);

        // ---- Program 3: input handshake ----
        new_prog();
        mv(8'h40, 8'h10);
        mv(8'h40, 8'h11);
        mv(8'h18, 8'h41);              expect_out(16'd42, "R8 input sum");
        mv(8'h40, 8'h41);              expect_out(16'hBEEF, "R8 input to output");
        park();
        do_reset();
        repeat (4) @(negedge clk);
        check(in_ready == 1'b1, "R8 ready while waiting", int'(in_ready), 1);
        check(imem_addr == 0, "R8 stall holds pc", int'(imem_addr), 0);
        in_q.push_back(16'd20);
        repeat (3) @(negedge clk);
        check(imem_addr == 1, "R8 first word taken", int'(imem_addr), 1);
        repeat (3) @(negedge clk);
        check(imem_addr == 1 && in_ready, "R8 second stall", int'(imem_addr), 1);
        in_q.push_back(16'd22);
        in_q.push_back(16'hBEEF);
        drain(100);

        // ---- Program 4: unmapped source ----
        new_prog();
        imm(16'd9, 8'h41);             expect_out(16'd9, "R10 before error");
        mv(8'h55, 8'h41);
        imm(16'h0033, 8'h41);
        park();
        do_reset();
        drain(100);
        check(error && halted, "R10 src error halts", int'({error, halted}), 3);
        begin
            logic [PW-1:0] held;
            held = imem_addr;
            repeat (5) @(negedge clk);
            check(imem_addr == held && error, "R10 frozen", int'(imem_addr), int'(held));
        end

        // ---- Program 5: unmapped destination ----
        new_prog();
        mv(8'h18, 8'h77);
        imm(16'h0044, 8'h41);
        park();
        do_reset();
        repeat (10) @(negedge clk);
        check(error && halted, "R10 dst error halts", int'({error, halted}), 3);
        check(imem_addr == 0, "R10 dst pc frozen", int'(imem_addr), 0);
        drain(10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule